// File: doc/BRIEF.md
# XTS Tweak Sequencer

This block wraps an external 128-bit block cipher and supplies the tweak handling that XTS mode needs. It holds a 128-bit tweak. Software or an upstream controller writes the initial tweak with a load strobe. For every data block it accepts, the block performs three steps:

- It XORs the block with the current tweak and presents the result to the cipher.
- It records that tweak in a small FIFO.
- It advances the stored tweak by one multiplication by x in GF(2^128).

Cipher results return in order. Each result is XORed with the tweak at the head of the FIFO. The result and the tweak it used leave the block together.

The tweak is little-endian: byte k occupies bits [8k+7:8k], and bit 0 is the least significant bit of the field element. Doubling is done on two 64-bit lanes. An explicit carry runs from the low lane into the high lane, and the reduction constant 0x87 is fed back into the low byte.

Encryption and decryption use the same tweak sequence and the same whitening, so the block has no direction input. Only the attached cipher changes direction. All three data paths use valid/ready handshakes. When the output stalls, the stall propagates back to the cipher.

Top module: `xts_tweak_seq`

## Requirements
- R1: After reset the stored tweak is zero and the FIFO is empty. While the FIFO is empty, `out_valid` and `cip_rsp_ready` stay low even if `cip_rsp_valid` is high. With `in_valid` low and `cip_req_ready` high, `in_ready` is high.
- R2: A cycle with `tweak_load` high replaces the stored tweak with `tweak_init`. In that cycle `in_ready` and `cip_req_valid` are low, so no block is accepted under the old or the new tweak.
- R3: Advancing shifts the 128-bit tweak left by one bit. Bit 63 moves into bit 64 across the lane boundary, and bit 0 receives zero before any reduction.
- R4: When bit 127 is set before an advance, 0x87 is XORed into bits [7:0] of the shifted value.
- R5: `cip_req_data` equals `in_data` XOR the current tweak. `cip_req_valid` follows `in_valid` when the FIFO is not full and no load is in progress.
- R6: `out_data` equals `cip_rsp_data` XOR the tweak that was current when the matching block was accepted. `out_tweak` carries that tweak. Results match blocks in acceptance order.
- R7: At most `FIFO_DEPTH` blocks are outstanding. With `FIFO_DEPTH` outstanding, `in_ready` and `cip_req_valid` are low.
- R8: While `out_ready` is low, `cip_rsp_ready` is low and the head tweak is held unchanged, so no response or tweak is lost.
- R9: The tweak advances exactly once for each input handshake (`in_valid` and `in_ready` both high). A stalled input does not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tweak_load | input | 1 | Load strobe for the initial tweak |
| tweak_init | input | 128 | Initial tweak value, little-endian |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Input block accepted when high with `in_valid` |
| in_data | input | 128 | Input data block |
| cip_req_valid | output | 1 | Pre-whitened block valid toward the cipher |
| cip_req_ready | input | 1 | Cipher can take a block |
| cip_req_data | output | 128 | Input block XOR tweak |
| cip_rsp_valid | input | 1 | Cipher result valid |
| cip_rsp_ready | output | 1 | Result taken by this block |
| cip_rsp_data | input | 128 | Cipher result |
| out_valid | output | 1 | Post-whitened result valid |
| out_ready | input | 1 | Downstream can take the result |
| out_data | output | 128 | Cipher result XOR its tweak |
| out_tweak | output | 128 | Tweak that whitened this result |

## Verification
A corrupted tweak register shows up in the very next `cip_req_data`, in the same cycle the next block is offered. From then on every later tweak is also wrong, because each one derives from the previous one. A wrong carry or a missing reduction appears only when bit 63 or bit 127 is set, so the bench loads tweaks that cross both boundaries within one or two blocks. A FIFO pointer or ordering fault is seen on `out_tweak` and `out_data` at the first result after the fault. This holds only when several blocks are in flight and the output is stalled, so the bench does exactly that.

// File: rtl/xts_tweak_pkg.sv
package xts_tweak_pkg;
  localparam int LANE_W  = 64;
  localparam int N_LANES = 2;
  localparam int BLK_W   = LANE_W * N_LANES;
  localparam logic [7:0] GF_FEEDBACK = 8'h87;

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [LANE_W-1:0] lane_t;

  // Multiply by x in GF(2^128), little-endian, processed as two lanes.
  function automatic blk_t gf_double(blk_t t);
    lane_t lo_in, hi_in, lo_out, hi_out;
    logic  carry_mid, carry_top;
    lo_in     = t[LANE_W-1:0];
    hi_in     = t[BLK_W-1:LANE_W];
    carry_mid = lo_in[LANE_W-1];
    carry_top = hi_in[LANE_W-1];
    lo_out    = {lo_in[LANE_W-2:0], 1'b0};
    hi_out    = {hi_in[LANE_W-2:0], carry_mid};
    if (carry_top) lo_out[7:0] = lo_out[7:0] ^ GF_FEEDBACK;
    return {hi_out, lo_out};
  endfunction
endpackage

// File: rtl/xts_tweak_reg.sv
module xts_tweak_reg
  import xts_tweak_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  blk_t load_val,
  input  logic adv_en,
  output blk_t tweak_q
);
  blk_t tweak_d;
  blk_t doubled;

  assign doubled = gf_double(tweak_q);

  always_comb begin
    tweak_d = tweak_q;
    if (load_en)     tweak_d = load_val;
    else if (adv_en) tweak_d = doubled;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tweak_q <= '0;
    else        tweak_q <= tweak_d;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> tweak_q == $past(load_val)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !adv_en) |=> $stable(tweak_q)); // R9
  AST_LANE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !load_en) |=> tweak_q[LANE_W] == $past(tweak_q[LANE_W-1])); // R3
  AST_SHIFT_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !load_en && !tweak_q[BLK_W-1]) |=> tweak_q[7:0] == {$past(tweak_q[6:0]), 1'b0}); // R3
  AST_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !load_en && tweak_q[BLK_W-1]) |=> tweak_q[7:0] == ({$past(tweak_q[6:0]), 1'b0} ^ 8'h87)); // R4
endmodule

// File: rtl/xts_tweak_fifo.sv
module xts_tweak_fifo
  import xts_tweak_pkg::*;
#(
  parameter int DEPTH = 8
)(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  blk_t din,
  input  logic pop,
  output blk_t dout,
  output logic full,
  output logic empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  blk_t        mem [DEPTH];
  logic [AW:0] wr_ptr, rd_ptr;
  logic        wr_fire, rd_fire;

  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign empty   = (wr_ptr == rd_ptr);
  assign wr_fire = push && !full;
  assign rd_fire = pop && !empty;
  assign dout    = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
      if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  initial begin
    assert (DEPTH >= 2 && (1 << AW) == DEPTH);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop); // R6
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> $stable(dout)); // R8
endmodule

// File: rtl/xts_whiten.sv
module xts_whiten
  import xts_tweak_pkg::*;
(
  input  blk_t pre_in,
  input  blk_t pre_tweak,
  input  blk_t post_in,
  input  blk_t post_tweak,
  output blk_t pre_out,
  output blk_t post_out
);
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign pre_out [g*LANE_W +: LANE_W] = pre_in [g*LANE_W +: LANE_W] ^ pre_tweak [g*LANE_W +: LANE_W];
    assign post_out[g*LANE_W +: LANE_W] = post_in[g*LANE_W +: LANE_W] ^ post_tweak[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/xts_tweak_seq.sv
module xts_tweak_seq
  import xts_tweak_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tweak_load,
  input  logic [127:0] tweak_init,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_data,
  output logic         cip_req_valid,
  input  logic         cip_req_ready,
  output logic [127:0] cip_req_data,
  input  logic         cip_rsp_valid,
  output logic         cip_rsp_ready,
  input  logic [127:0] cip_rsp_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_data,
  output logic [127:0] out_tweak
);
  blk_t tweak_cur;
  blk_t head_tweak;
  logic fifo_full, fifo_empty;

  // Named internal events
  logic accept_ev;
  logic retire_ev;
  logic gate_open;

  assign gate_open     = !fifo_full && !tweak_load;
  assign in_ready      = cip_req_ready && gate_open;
  assign cip_req_valid = in_valid && gate_open;
  assign accept_ev     = in_valid && in_ready;

  assign out_valid     = cip_rsp_valid && !fifo_empty;
  assign cip_rsp_ready = out_ready && !fifo_empty;
  assign retire_ev     = out_valid && out_ready;
  assign out_tweak     = head_tweak;

  xts_tweak_reg u_tweak (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (tweak_load),
    .load_val (tweak_init),
    .adv_en   (accept_ev),
    .tweak_q  (tweak_cur)
  );

  xts_tweak_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept_ev),
    .din   (tweak_cur),
    .pop   (retire_ev),
    .dout  (head_tweak),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  xts_whiten u_whiten (
    .pre_in     (in_data),
    .pre_tweak  (tweak_cur),
    .post_in    (cip_rsp_data),
    .post_tweak (head_tweak),
    .pre_out    (cip_req_data),
    .post_out   (out_data)
  );

  AST_NO_RETIRE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> (!out_valid && !cip_rsp_ready)); // R1
  AST_LOAD_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    tweak_load |=> $past(!accept_ev)); // R2
endmodule

// File: tb/xts_tweak_seq_bench.sv
module xts_tweak_seq_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic tweak_load = 0;
  logic [127:0] tweak_init = '0;
  logic in_valid = 0, in_ready;
  logic [127:0] in_data = '0;
  logic cip_req_valid, cip_req_ready = 0;
  logic [127:0] cip_req_data;
  logic cip_rsp_valid = 0, cip_rsp_ready;
  logic [127:0] cip_rsp_data = '0;
  logic out_valid, out_ready = 0;
  logic [127:0] out_data, out_tweak;

  always #(CLK_P/2) clk = ~clk;

  xts_tweak_seq #(.FIFO_DEPTH(DEPTH)) u_xts_tweak_seq (
    .clk(clk), .rst_n(rst_n), .tweak_load(tweak_load), .tweak_init(tweak_init),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cip_req_valid(cip_req_valid), .cip_req_ready(cip_req_ready), .cip_req_data(cip_req_data),
    .cip_rsp_valid(cip_rsp_valid), .cip_rsp_ready(cip_rsp_ready), .cip_rsp_data(cip_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_tweak(out_tweak)
  );

  int n_total = 0, n_fail = 0;
  bit done = 0;

  // knobs: 0 off, 1 on, 2 random
  int k_req = 1, k_rsp = 1, k_out = 1;
  bit load_now = 0;
  logic [127:0] load_val = '0;
  logic [127:0] model_t = '0;
  logic [127:0] src_q[$];
  logic [127:0] cip_q[$];
  logic [127:0] exp_pt[$];
  logic [127:0] exp_tw[$];
  logic [127:0] req_log[$];
  int acc_cnt = 0;

  function automatic logic [127:0] ref_double(logic [127:0] t);
    logic [127:0] r;
    r = t << 1;
    if (t[127]) r = r ^ 128'h87;
    return r;
  endfunction

  function automatic logic [127:0] toy_cipher(logic [127:0] x);
    return {x[119:0], x[127:120]} ^ 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  endfunction

  function automatic bit knob(int k);
    if (k == 2) return bit'($urandom_range(0, 1));
    return k == 1;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] expv);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // driver: applies inputs for one cycle, records expected items at handshake
  task automatic drive_phase();
    @(negedge clk);
    tweak_load    = load_now;
    tweak_init    = load_val;
    in_valid      = src_q.size() > 0;
    in_data       = (src_q.size() > 0) ? src_q[0] : '0;
    cip_req_ready = knob(k_req);
    cip_rsp_valid = (cip_q.size() > 0) && knob(k_rsp);
    cip_rsp_data  = (cip_q.size() > 0) ? toy_cipher(cip_q[0]) : '0;
    out_ready     = knob(k_out);
    #(CLK_P/4);
    if (tweak_load) chk(!in_ready && !cip_req_valid, "R2 no accept on load", {127'b0, in_ready}, '0);
    if (in_valid && in_ready) begin
      chk(cip_req_data == (in_data ^ model_t), "R5 pre-whiten", cip_req_data, in_data ^ model_t);
      req_log.push_back(cip_req_data);
      cip_q.push_back(cip_req_data);
      exp_pt.push_back(in_data);
      exp_tw.push_back(model_t);
      void'(src_q.pop_front());
      model_t = ref_double(model_t);
      acc_cnt++;
    end
    if (load_now) begin
      model_t  = load_val;
      load_now = 0;
    end
  endtask

  // monitor: pops expected items as results retire
  task automatic monitor_phase();
    logic [127:0] pt, tw, e;
    if (cip_rsp_valid && cip_rsp_ready) begin
      void'(cip_q.pop_front());
      chk(out_valid && out_ready, "R6 retire pairing", {127'b0, out_valid}, 128'h1);
    end
    if (out_valid && out_ready) begin
      if (exp_tw.size() == 0) begin
        chk(0, "R6 unexpected output", out_data, '0);
      end else begin
        pt = exp_pt.pop_front();
        tw = exp_tw.pop_front();
        e  = toy_cipher(pt ^ tw) ^ tw;
        chk(out_tweak == tw, "R6 out_tweak order", out_tweak, tw);
        chk(out_data == e, "R6 post-whiten", out_data, e);
      end
    end
  endtask

  task automatic step();
    drive_phase();
    monitor_phase();
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      if (src_q.size() == 0 && exp_tw.size() == 0) break;
      step();
    end
    chk(src_q.size() == 0 && exp_tw.size() == 0, "R6 drain complete",
        128'(exp_tw.size()), '0);
  endtask

  task automatic do_load(logic [127:0] v);
    load_val = v;
    load_now = 1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cip_req_ready = 1; cip_rsp_valid = 1; out_ready = 1;
    #(CLK_P/4);
    // R1 reset state
    chk(in_ready == 1, "R1 in_ready after reset", {127'b0, in_ready}, 128'h1);
    chk(!out_valid && !cip_rsp_ready, "R1 empty fifo blocks output", {126'b0, out_valid, cip_rsp_ready}, '0);
    chk(cip_req_data == in_data, "R1 tweak zero after reset", cip_req_data, in_data);

    // R3 lane carry under random handshakes
    do_load(128'h0000_0000_0000_0000_4000_0000_0000_0001);
    k_req = 2; k_rsp = 2; k_out = 2;
    for (int i = 0; i < 12; i++) src_q.push_back({$urandom, $urandom, $urandom, $urandom});
    drain();
    chk(exp_tw.size() == 0 && acc_cnt == 12, "R3 lane-crossing sequence", 128'(acc_cnt), 128'd12);

    // R4 wrap with feedback, both lane tops set
    k_req = 1; k_rsp = 1; k_out = 1;
    do_load(128'h8000_0000_0000_0000_8000_0000_0000_0000);
    req_log.delete();
    for (int i = 0; i < 8; i++) src_q.push_back('0);
    drain();
    chk(req_log.size() == 8, "R4 eight blocks taken", 128'(req_log.size()), 128'd8);
    if (req_log.size() >= 2)
      chk(req_log[1] == 128'h0000_0000_0000_0001_0000_0000_0000_0087, "R4 wrap feedback 0x87",
          req_log[1], 128'h0000_0000_0000_0001_0000_0000_0000_0087);

    // R7 fill fifo with cipher holding results
    k_rsp = 0;
    acc_cnt = 0;
    for (int i = 0; i < DEPTH + 3; i++) src_q.push_back({4{$urandom}});
    for (int i = 0; i < DEPTH + 5; i++) step();
    chk(acc_cnt == DEPTH, "R7 accepted count at depth", 128'(acc_cnt), 128'(DEPTH));
    chk(!in_ready && !cip_req_valid, "R7 input closed when full", {126'b0, in_ready, cip_req_valid}, '0);

    // R8 output stalled: cipher must see backpressure
    k_rsp = 1; k_out = 0;
    for (int i = 0; i < 4; i++) step();
    chk(!cip_rsp_ready && out_valid, "R8 backpressure to cipher", {126'b0, cip_rsp_ready, out_valid}, 128'h1);
    chk(cip_q.size() == DEPTH, "R8 no response consumed", 128'(cip_q.size()), 128'(DEPTH));
    k_out = 2;
    drain();

    // R9 stalled input does not advance tweak
    k_req = 0;
    acc_cnt = 0;
    src_q.push_back(128'hdead_beef_0000_1111_2222_3333_4444_5555);
    for (int i = 0; i < 5; i++) step();
    chk(acc_cnt == 0 && !in_ready, "R9 stall holds block", 128'(acc_cnt), '0);
    k_req = 1;
    src_q.push_back(128'h5555);
    drain();
    chk(acc_cnt == 2, "R9 one advance per block", 128'(acc_cnt), 128'd2);

    // R2 load while input valid, then random traffic
    k_req = 2; k_rsp = 2; k_out = 2;
    for (int i = 0; i < 20; i++) src_q.push_back({4{$urandom}});
    step(); step();
    do_load(128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff);
    drain();
    do_load(128'h8000_0000_0000_0001_0000_0000_0000_0000);
    for (int i = 0; i < 16; i++) src_q.push_back({4{$urandom}});
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule